// File: doc/BRIEF.md
# NAND Flash Instruction Sequencer

The block runs a short, software-written program of flash bus operations. Up to nine six-bit opcode slots are packed into two program words. The slots cover several kinds of step: command-byte writes, address phases, data reads and writes, a status read, and a terminator. The sequencer walks the slots in order after a start pulse. For each step it drives an abstracted flash bus with one strobe per cycle: command, address, write data or read data. It also watches a ready/busy line and a write-protect line.

Read data lands in an internal page buffer and write data is taken from it. The host reaches the buffer through a simple byte port while the sequencer is idle. The buffer holds several page-sized regions, each twice the page size. The region for a transaction is picked by masking the row address. A flag in the column word moves the data pointer into the spare half of that region.

Three sticky event bits report how each program ended. One marks completion, one marks a ready timeout and one marks a write-protect violation. Software clears them by writing ones.

Top module: `nand_op_sequencer`

## Requirements
- R1: Slot k (k=0..4) is `prog_lo[29-6k -: 6]` and slot 5+k (k=0..3) is `prog_hi[23-6k -: 6]`. Slots execute strictly in ascending order, and a sequence starts on a `start` pulse while idle.
- R2: Opcodes 1..4 issue one command strobe. The byte on `fl_dout` is `cmd_bytes[8i+7:8i]`, where i = opcode-1.
- R3: Opcode 5 issues two address strobes: `col_addr[7:0]`, then `{1'b0,col_addr[14:8]}`. Opcode 6 issues three: `row_addr` bytes, least significant first. Opcode 7 issues one: `usr_addr`.
- R4: The data opcodes move `byte_cnt` bytes, or PAGE_BYTES+SPARE_BYTES bytes when `byte_cnt` is zero. Opcode 8 reads at once, opcode 9 first waits for ready and then reads, and opcode 10 writes.
- R5: Data starts at buffer address `(row_addr & buf_mask)*2*PAGE_BYTES + (col_addr[15] ? PAGE_BYTES : 0) + col_addr[14:0]` and advances by one per byte. Read bytes are stored there and write bytes are sent from there.
- R6: Opcode 0, any undefined opcode, or running past slot 8 ends the sequence. `busy` then drops and status bit 0 (done) sets.
- R7: Opcodes 9 and 11 wait while `fl_rdy` is low. If it stays low for `rb_limit` consecutive wait cycles, status bit 1 and bit 0 set and the sequence aborts with no further strobes.
- R8: Opcode 10 starting while `fl_wp` is high sets status bits 2 and 0. No write strobe is issued and no later slot runs.
- R9: Opcode 11 waits for ready, then takes one read strobe and places `fl_din` in `flash_stat[31:24]`.
- R10: Writing with `clr_we` clears the status bits set in `clr_mask`. An event setting a bit in the same cycle wins.
- R11: `fl_cs` is one-hot on `bank_sel` while busy and all zero while idle.
- R12: After reset, the block is idle and status, `flash_stat`, strobes and `fl_cs` are all zero.
- R13: At most one flash strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the program (sampled while idle) |
| prog_lo | input | 30 | Opcode slots 0..4 |
| prog_hi | input | 24 | Opcode slots 5..8 |
| cmd_bytes | input | 32 | Four command bytes |
| col_addr | input | 16 | Column; bit 15 selects spare half |
| row_addr | input | 24 | Row (page) address |
| usr_addr | input | 8 | User address byte |
| byte_cnt | input | CNT_W | Transfer length, 0 = page plus spare |
| buf_mask | input | BW | Mask selecting the buffer region from the row |
| bank_sel | input | CSW | Target bank number |
| rb_limit | input | TMO_W | Ready wait limit in cycles (non-zero) |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 3 | Status bits to clear |
| status | output | 3 | {wp error, timeout, done} |
| busy | output | 1 | Sequence running |
| flash_stat | output | 32 | Captured device status in bits 31:24 |
| host_we | input | 1 | Host buffer write (ignored while busy) |
| host_addr | input | AW | Host buffer address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| fl_cs | output | NUM_BANKS | Bank select, one-hot |
| fl_cmd_stb | output | 1 | Command byte strobe |
| fl_addr_stb | output | 1 | Address byte strobe |
| fl_wr_stb | output | 1 | Write data strobe |
| fl_rd_stb | output | 1 | Read data strobe |
| fl_dout | output | 8 | Byte toward the flash |
| fl_din | input | 8 | Byte from the flash |
| fl_rdy | input | 1 | Device ready |
| fl_wp | input | 1 | Write protect active |

## Verification
The end-of-sequence event and a software clear of the same status bit can land on one clock edge. The bench provokes this by starting a program with one command slot followed by a terminator. It holds a clear of the done bit across the edge on which the terminator is decoded, then checks that done reads one afterwards. A second coincidence is covered the same way: the read strobe and the page-buffer write happen in one cycle. The bench judges it by reading the buffer back through the host port and comparing against the bytes the flash model supplied.

// File: rtl/nsq_pkg.sv
package nsq_pkg;
    localparam int SLOTS = 9;
    localparam int ST_DONE = 0;
    localparam int ST_TMO  = 1;
    localparam int ST_WPE  = 2;

    typedef enum logic [5:0] {
        OP_NOP  = 6'd0,
        OP_CMD0 = 6'd1,
        OP_CMD1 = 6'd2,
        OP_CMD2 = 6'd3,
        OP_CMD3 = 6'd4,
        OP_COL  = 6'd5,
        OP_ROW  = 6'd6,
        OP_USR  = 6'd7,
        OP_RDF  = 6'd8,
        OP_RDW  = 6'd9,
        OP_WRC  = 6'd10,
        OP_STAT = 6'd11
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_WAIT = 2'd2,
        PH_MOVE = 2'd3
    } phase_e;
endpackage

// File: rtl/nsq_slot_decode.sv
module nsq_slot_decode
    import nsq_pkg::*;
(
    input  logic [29:0] prog_lo,
    input  logic [23:0] prog_hi,
    input  logic [3:0]  slot,
    output logic [5:0]  op
);
    logic [5:0] fld [SLOTS];

    // R1: slot field positions
    for (genvar g = 0; g < 5; g++) begin : g_lo
        assign fld[g] = prog_lo[29-6*g -: 6];
    end
    for (genvar g = 5; g < SLOTS; g++) begin : g_hi
        assign fld[g] = prog_hi[23-6*(g-5) -: 6];
    end

    // past the last slot reads as a terminator (R6)
    always_comb op = (slot < 4'(SLOTS)) ? fld[slot] : 6'd0;
endmodule

// File: rtl/nsq_pagebuf.sv
module nsq_pagebuf #(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/nand_op_sequencer.sv
module nand_op_sequencer
    import nsq_pkg::*;
#(
    parameter int PAGE_BYTES  = 16,
    parameter int SPARE_BYTES = 8,
    parameter int NUM_BUFS    = 4,
    parameter int NUM_BANKS   = 4,
    parameter int CNT_W       = 8,
    parameter int TMO_W       = 16,
    localparam int AW  = $clog2(NUM_BUFS*2*PAGE_BYTES),
    localparam int BW  = $clog2(NUM_BUFS),
    localparam int CSW = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [29:0]          prog_lo,
    input  logic [23:0]          prog_hi,
    input  logic [31:0]          cmd_bytes,
    input  logic [15:0]          col_addr,
    input  logic [23:0]          row_addr,
    input  logic [7:0]           usr_addr,
    input  logic [CNT_W-1:0]     byte_cnt,
    input  logic [BW-1:0]        buf_mask,
    input  logic [CSW-1:0]       bank_sel,
    input  logic [TMO_W-1:0]     rb_limit,
    input  logic                 clr_we,
    input  logic [2:0]           clr_mask,
    output logic [2:0]           status,
    output logic                 busy,
    output logic [31:0]          flash_stat,
    input  logic                 host_we,
    input  logic [AW-1:0]        host_addr,
    input  logic [7:0]           host_wdata,
    output logic [7:0]           host_rdata,
    output logic [NUM_BANKS-1:0] fl_cs,
    output logic                 fl_cmd_stb,
    output logic                 fl_addr_stb,
    output logic                 fl_wr_stb,
    output logic                 fl_rd_stb,
    output logic [7:0]           fl_dout,
    input  logic [7:0]           fl_din,
    input  logic                 fl_rdy,
    input  logic                 fl_wp
);
    localparam int LW = CNT_W + 1;
    localparam int PW = $clog2(2*PAGE_BYTES);

    typedef struct packed {
        phase_e           ph;
        logic [3:0]       slot;
        logic [LW-1:0]    k;
        logic [AW-1:0]    ptr;
        logic [TMO_W-1:0] tmr;
        logic [2:0]       stat;
        logic [7:0]       fsr;
    } st_t;

    st_t s_q, s_d;

    logic [5:0]    op_raw;
    op_e           opc;
    logic [LW-1:0] len;
    logic [AW-1:0] start_ptr;
    logic [BW-1:0] bufnum;
    logic [7:0]    buf_q;
    logic          seq_we, last, finish;
    logic [2:0]    set_ev;
    logic [1:0]    cidx;

    nsq_slot_decode u_dec (
        .prog_lo (prog_lo),
        .prog_hi (prog_hi),
        .slot    (s_q.slot),
        .op      (op_raw)
    );

    nsq_pagebuf #(.DEPTH(NUM_BUFS*2*PAGE_BYTES), .AW(AW)) u_buf (
        .clk     (clk),
        .we      (seq_we | (host_we & ~busy)),
        .waddr   (seq_we ? s_q.ptr : host_addr),
        .wdata   (seq_we ? fl_din : host_wdata),
        .raddr_a (host_addr),
        .rdata_a (host_rdata),
        .raddr_b (s_q.ptr),
        .rdata_b (buf_q)
    );

    assign opc    = op_e'(op_raw);
    assign cidx   = op_raw[1:0] - 2'd1;
    assign bufnum = row_addr[BW-1:0] & buf_mask;
    // R5: region base, spare half, column offset
    assign start_ptr = (AW'(bufnum) << PW)
                     + (col_addr[15] ? AW'(PAGE_BYTES) : AW'(0))
                     + AW'(col_addr[14:0]);
    // R4: zero count means whole page plus spare
    assign len = (byte_cnt == '0) ? LW'(PAGE_BYTES + SPARE_BYTES) : LW'(byte_cnt);

    always_comb begin
        s_d         = s_q;
        fl_cmd_stb  = 1'b0;
        fl_addr_stb = 1'b0;
        fl_wr_stb   = 1'b0;
        fl_rd_stb   = 1'b0;
        fl_dout     = 8'h00;
        seq_we      = 1'b0;
        last        = 1'b0;
        finish      = 1'b0;
        set_ev      = 3'b000;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph   = PH_RUN;
                    s_d.slot = '0;
                end
            end
            PH_RUN: begin
                s_d.k   = '0;
                s_d.tmr = '0;
                case (opc)
                    OP_CMD0, OP_CMD1, OP_CMD2, OP_CMD3: begin
                        fl_cmd_stb = 1'b1;
                        fl_dout    = cmd_bytes[8*cidx +: 8];
                        s_d.slot   = s_q.slot + 4'd1;
                    end
                    OP_COL, OP_ROW, OP_USR: s_d.ph = PH_MOVE;
                    OP_RDF: begin
                        s_d.ph  = PH_MOVE;
                        s_d.ptr = start_ptr;
                    end
                    OP_RDW: begin
                        s_d.ph  = PH_WAIT;
                        s_d.ptr = start_ptr;
                    end
                    OP_STAT: s_d.ph = PH_WAIT;
                    OP_WRC: begin
                        if (fl_wp) begin
                            set_ev[ST_WPE] = 1'b1;
                            finish         = 1'b1;
                        end else begin
                            s_d.ph  = PH_MOVE;
                            s_d.ptr = start_ptr;
                        end
                    end
                    default: finish = 1'b1;
                endcase
            end
            PH_WAIT: begin
                if (fl_rdy) begin
                    s_d.ph = PH_MOVE;
                end else begin
                    s_d.tmr = s_q.tmr + 1'b1;
                    if (s_d.tmr == rb_limit) begin
                        set_ev[ST_TMO] = 1'b1;
                        finish         = 1'b1;
                    end
                end
            end
            PH_MOVE: begin
                case (opc)
                    OP_COL: begin
                        fl_addr_stb = 1'b1;
                        fl_dout     = (s_q.k == '0) ? col_addr[7:0] : {1'b0, col_addr[14:8]};
                        last        = (s_q.k == LW'(1));
                    end
                    OP_ROW: begin
                        fl_addr_stb = 1'b1;
                        case (s_q.k[1:0])
                            2'd0:    fl_dout = row_addr[7:0];
                            2'd1:    fl_dout = row_addr[15:8];
                            default: fl_dout = row_addr[23:16];
                        endcase
                        last = (s_q.k == LW'(2));
                    end
                    OP_USR: begin
                        fl_addr_stb = 1'b1;
                        fl_dout     = usr_addr;
                        last        = 1'b1;
                    end
                    OP_RDF, OP_RDW: begin
                        fl_rd_stb = 1'b1;
                        seq_we    = 1'b1;
                        s_d.ptr   = s_q.ptr + 1'b1;
                        last      = (s_q.k == len - 1'b1);
                    end
                    OP_WRC: begin
                        fl_wr_stb = 1'b1;
                        fl_dout   = buf_q;
                        s_d.ptr   = s_q.ptr + 1'b1;
                        last      = (s_q.k == len - 1'b1);
                    end
                    default: begin
                        fl_rd_stb = 1'b1;
                        s_d.fsr   = fl_din;
                        last      = 1'b1;
                    end
                endcase
                if (last) begin
                    s_d.ph   = PH_RUN;
                    s_d.slot = s_q.slot + 4'd1;
                end else begin
                    s_d.k = s_q.k + 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
        if (finish) begin
            s_d.ph          = PH_IDLE;
            set_ev[ST_DONE] = 1'b1;
        end
        // R10: clear by ones, a same-cycle event wins
        s_d.stat = (s_q.stat & ~(clr_we ? clr_mask : 3'b000)) | set_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy       = (s_q.ph != PH_IDLE);
    assign status     = s_q.stat;
    assign flash_stat = {s_q.fsr, 24'h000000};
    assign fl_cs      = busy ? (NUM_BANKS'(1) << bank_sel) : '0;

    a_r13_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fl_cmd_stb, fl_addr_stb, fl_wr_stb, fl_rd_stb}));

    a_r11_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (fl_cs == '0));

    a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> status[ST_DONE]);

    a_r7_timeout_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_TMO]) |-> (!busy && $past(!fl_rdy)));

    a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(fl_cmd_stb | fl_addr_stb | fl_wr_stb | fl_rd_stb));
endmodule

// File: tb/nand_op_sequencer_tb_top.sv
`timescale 1ns/1ps
module nand_op_sequencer_tb_top;
    import nsq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [29:0] prog_lo = '0;
    logic [23:0] prog_hi = '0;
    logic [31:0] cmd_bytes = '0;
    logic [15:0] col_addr = '0;
    logic [23:0] row_addr = '0;
    logic [7:0]  usr_addr = '0;
    logic [7:0]  byte_cnt = '0;
    logic [1:0]  buf_mask = '0;
    logic [1:0]  bank_sel = '0;
    logic [15:0] rb_limit = 16'd1000;
    logic        clr_we = 1'b0;
    logic [2:0]  clr_mask = '0;
    logic [2:0]  status;
    logic        busy;
    logic [31:0] flash_stat;
    logic        host_we = 1'b0;
    logic [6:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [3:0]  fl_cs;
    logic        fl_cmd_stb, fl_addr_stb, fl_wr_stb, fl_rd_stb;
    logic [7:0]  fl_dout;
    logic [7:0]  fl_din;
    logic        fl_rdy = 1'b1;
    logic        fl_wp = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int rd_idx = 0;
    int ev_n = 0;
    int ev_kind [1024];
    logic [7:0] ev_byte [1024];
    int exp_n = 0;
    int exp_kind [256];
    logic [7:0] exp_byte [256];
    int log_base = 0;
    int rd_base = 0;

    always #2.5 clk = ~clk;

    nand_op_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .prog_lo(prog_lo), .prog_hi(prog_hi),
        .cmd_bytes(cmd_bytes), .col_addr(col_addr), .row_addr(row_addr), .usr_addr(usr_addr),
        .byte_cnt(byte_cnt), .buf_mask(buf_mask), .bank_sel(bank_sel), .rb_limit(rb_limit),
        .clr_we(clr_we), .clr_mask(clr_mask), .status(status), .busy(busy),
        .flash_stat(flash_stat), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .fl_cs(fl_cs),
        .fl_cmd_stb(fl_cmd_stb), .fl_addr_stb(fl_addr_stb), .fl_wr_stb(fl_wr_stb),
        .fl_rd_stb(fl_rd_stb), .fl_dout(fl_dout), .fl_din(fl_din), .fl_rdy(fl_rdy),
        .fl_wp(fl_wp)
    );

    function automatic logic [7:0] patt(input int i);
        return 8'h40 + 8'(i);
    endfunction

    assign fl_din = patt(rd_idx);

    // flash model: advance read data after each consumed read strobe
    always @(posedge clk) if (fl_rd_stb) rd_idx <= rd_idx + 1;

    // bus monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (fl_cmd_stb)  begin ev_kind[ev_n] = 1; ev_byte[ev_n] = fl_dout; ev_n = ev_n + 1; end
            if (fl_addr_stb) begin ev_kind[ev_n] = 2; ev_byte[ev_n] = fl_dout; ev_n = ev_n + 1; end
            if (fl_wr_stb)   begin ev_kind[ev_n] = 3; ev_byte[ev_n] = fl_dout; ev_n = ev_n + 1; end
            if (fl_rd_stb)   begin ev_kind[ev_n] = 4; ev_byte[ev_n] = fl_din;  ev_n = ev_n + 1; end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [29:0] lo5(input op_e a, b, c, d, e);
        return {a, b, c, d, e};
    endfunction

    function automatic logic [23:0] hi4(input op_e a, b, c, d);
        return {a, b, c, d};
    endfunction

    task automatic push_exp(input int kd, input logic [7:0] b);
        exp_kind[exp_n] = kd;
        exp_byte[exp_n] = b;
        exp_n++;
    endtask

    task automatic begin_log();
        @(negedge clk);
        log_base = ev_n;
        rd_base  = rd_idx;
        exp_n    = 0;
    endtask

    task automatic check_log(input string req);
        chk(ev_n - log_base == exp_n, {req, " event count"}, ev_n - log_base, exp_n);
        for (int i = 0; i < exp_n; i++) begin
            chk(ev_kind[log_base+i] == exp_kind[i] && ev_byte[log_base+i] == exp_byte[i],
                {req, " event"}, {ev_kind[log_base+i][7:0], ev_byte[log_base+i]},
                {exp_kind[i][7:0], exp_byte[i]});
        end
    endtask

    task automatic run_prog();
        int cyc = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (busy && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_we = 1'b1; clr_mask = 3'b111;
        @(negedge clk);
        clr_we = 1'b0; clr_mask = 3'b000;
    endtask

    task automatic host_write(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input logic [6:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic t_reset();
        chk(status == 3'b000, "R12 status", status, 0);
        chk(!busy, "R12 busy", busy, 0);
        chk(flash_stat == 32'h0, "R12 flash_stat", flash_stat, 0);
        chk(fl_cs == 4'h0, "R12 cs", fl_cs, 0);
        chk(!(fl_cmd_stb | fl_addr_stb | fl_wr_stb | fl_rd_stb), "R12 strobes", 0, 0);
    endtask

    task automatic t_full_page_read();
        logic [7:0] d;
        clear_all();
        prog_lo = lo5(OP_CMD0, OP_COL, OP_ROW, OP_CMD1, OP_RDW);
        prog_hi = hi4(OP_NOP, OP_NOP, OP_NOP, OP_NOP);
        cmd_bytes = 32'h0000_3000;
        col_addr = 16'h0000; row_addr = 24'h000005; buf_mask = 2'b11; byte_cnt = 8'd0;
        fl_rdy = 1'b1;
        begin_log();
        push_exp(1, 8'h00);
        push_exp(2, 8'h00); push_exp(2, 8'h00);
        push_exp(2, 8'h05); push_exp(2, 8'h00); push_exp(2, 8'h00);
        push_exp(1, 8'h30);
        for (int j = 0; j < 24; j++) push_exp(4, patt(rd_base + j));
        run_prog();
        check_log("R1 R2 R3 R4 full read");
        // region 1 (5 & 3), base 32
        for (int j = 0; j < 24; j++) begin
            host_read(7'(32 + j), d);
            chk(d == patt(rd_base + j), "R5 buffer fill", d, patt(rd_base + j));
        end
        chk(status == 3'b001, "R6 done after read", status, 3'b001);
    endtask

    task automatic t_spare_read();
        logic [7:0] d;
        clear_all();
        prog_lo = lo5(OP_RDF, OP_NOP, OP_NOP, OP_NOP, OP_NOP);
        col_addr = 16'h8002; row_addr = 24'h000002; buf_mask = 2'b11; byte_cnt = 8'd4;
        begin_log();
        for (int j = 0; j < 4; j++) push_exp(4, patt(rd_base + j));
        run_prog();
        check_log("R4 counted read");
        // region 2 base 64, +16 spare, +2 column = 82
        for (int j = 0; j < 4; j++) begin
            host_read(7'(82 + j), d);
            chk(d == patt(rd_base + j), "R5 spare placement", d, patt(rd_base + j));
        end
    endtask

    task automatic t_program_and_status();
        clear_all();
        buf_mask = 2'b00; col_addr = 16'h0003; row_addr = 24'h012345; byte_cnt = 8'd3;
        host_write(7'd3, 8'hC1);
        host_write(7'd4, 8'hC2);
        host_write(7'd5, 8'hC3);
        cmd_bytes = 32'h0000_1080;
        prog_lo = lo5(OP_CMD0, OP_COL, OP_ROW, OP_WRC, OP_CMD1);
        prog_hi = hi4(OP_STAT, OP_NOP, OP_NOP, OP_NOP);
        rb_limit = 16'd1000;
        fl_rdy = 1'b0;
        begin_log();
        push_exp(1, 8'h80);
        push_exp(2, 8'h03); push_exp(2, 8'h00);
        push_exp(2, 8'h45); push_exp(2, 8'h23); push_exp(2, 8'h01);
        push_exp(3, 8'hC1); push_exp(3, 8'hC2); push_exp(3, 8'hC3);
        push_exp(1, 8'h10);
        push_exp(4, patt(rd_base));
        fork
            begin
                repeat (30) @(negedge clk);
                fl_rdy = 1'b1;
            end
        join_none
        run_prog();
        check_log("R1 R5 write then status");
        chk(flash_stat[31:24] == patt(rd_base), "R9 status byte", flash_stat[31:24], patt(rd_base));
        chk(flash_stat[23:0] == 24'h0, "R9 low bits", flash_stat[23:0], 0);
        chk(status == 3'b001, "R7 no timeout when ready comes", status, 3'b001);
    endtask

    task automatic t_timeout();
        clear_all();
        prog_lo = lo5(OP_CMD0, OP_RDW, OP_CMD1, OP_NOP, OP_NOP);
        cmd_bytes = 32'h0000_3000; rb_limit = 16'd10; byte_cnt = 8'd2;
        fl_rdy = 1'b0;
        begin_log();
        push_exp(1, 8'h00);
        run_prog();
        check_log("R7 abort on timeout");
        chk(status == 3'b011, "R7 timeout bits", status, 3'b011);
        fl_rdy = 1'b1;
        rb_limit = 16'd1000;
    endtask

    task automatic t_write_protect();
        clear_all();
        prog_lo = lo5(OP_WRC, OP_CMD0, OP_NOP, OP_NOP, OP_NOP);
        byte_cnt = 8'd2; fl_wp = 1'b1;
        begin_log();
        run_prog();
        check_log("R8 no strobes under protect");
        chk(status == 3'b101, "R8 wp bits", status, 3'b101);
        fl_wp = 1'b0;
    endtask

    task automatic t_w1c();
        // status is 101 from the previous scenario
        @(negedge clk);
        clr_we = 1'b1; clr_mask = 3'b100;
        @(negedge clk);
        clr_we = 1'b0;
        chk(status == 3'b001, "R10 partial clear", status, 3'b001);
        clr_we = 1'b1; clr_mask = 3'b001;
        @(negedge clk);
        clr_we = 1'b0;
        chk(status == 3'b000, "R10 full clear", status, 3'b000);
    endtask

    task automatic t_nine_slots();
        clear_all();
        cmd_bytes = 32'h4433_2211;
        prog_lo = lo5(OP_CMD0, OP_CMD1, OP_CMD2, OP_CMD3, OP_CMD0);
        prog_hi = hi4(OP_CMD1, OP_CMD2, OP_CMD3, OP_CMD0);
        begin_log();
        for (int j = 0; j < 9; j++) push_exp(1, 8'((j % 4 + 1) * 8'h11));
        run_prog();
        check_log("R6 end after last slot");
        chk(status == 3'b001, "R6 done", status, 3'b001);
    endtask

    task automatic t_user_addr();
        clear_all();
        usr_addr = 8'h7E; col_addr = 16'h8123;
        prog_lo = {OP_USR, OP_COL, 6'h3F, OP_CMD0, OP_CMD0};
        prog_hi = hi4(OP_NOP, OP_NOP, OP_NOP, OP_NOP);
        begin_log();
        push_exp(2, 8'h7E); push_exp(2, 8'h23); push_exp(2, 8'h01);
        run_prog();
        check_log("R3 user and column bytes, R6 undefined op ends");
    endtask

    task automatic t_clear_vs_done();
        clear_all();
        bank_sel = 2'd2;
        cmd_bytes = 32'h0000_00FF;
        prog_lo = lo5(OP_CMD0, OP_NOP, OP_NOP, OP_NOP, OP_NOP);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy, "R1 started", busy, 1);
        chk(fl_cs == 4'b0100, "R11 bank select", fl_cs, 4'b0100);
        chk(status[0] == 1'b0, "R6 not yet done", status, 0);
        clr_we = 1'b1; clr_mask = 3'b001;
        @(negedge clk);
        chk(busy, "R6 still running", busy, 1);
        @(negedge clk);
        chk(!busy, "R6 finished", busy, 0);
        chk(status[0] == 1'b1, "R10 set wins over clear", status, 3'b001);
        clr_we = 1'b0;
        @(negedge clk);
        chk(fl_cs == 4'b0000, "R11 idle deselect", fl_cs, 0);
        bank_sel = 2'd0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_full_page_read();
        t_spare_read();
        t_program_and_status();
        t_timeout();
        t_write_protect();
        t_w1c();
        t_nine_slots();
        t_user_addr();
        t_clear_vs_done();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule